// File: doc/BRIEF.md
# Phase-Coherent Three-Oscillator Hop Selector

This block holds three numerically controlled oscillators for the first down-conversion path of one receive channel. Each oscillator is a 32-bit phase accumulator stepped by its own 32-bit frequency word. All three accumulators advance on every accepted sample, whichever one is in use. A hop from one oscillator to another therefore lands on the phase that the new oscillator would have had if it had been running alone. The output is the upper 16 bits of the active accumulator. It is registered and goes to a downstream sine/cosine generator and mixer.

The 2-bit hop code comes from one of two places, chosen by a source bit. The first is a register field. The second is a pair of general-purpose pins, and two remap fields decide which of the four pins drives each code bit. Pin inputs are synchronized before use. The code 11 names no oscillator, so the block keeps the previous choice and latches an error flag.

Each receive channel uses its own instance, with its own control fields. Other down-conversion paths keep a single fixed oscillator and do not use this block.

Top module: `hop_nco_bank`

## Requirements
- R1: After reset, phase_out is 0, phase_valid is 0, invalid_sel is 0, all accumulators and frequency words are 0, and the held choice is NCO1, so a first sample carrying code 11 uses NCO1.
- R2: Every accumulator adds its own frequency word on each clock with in_valid=1, whatever the selection; with in_valid=0 no accumulator changes.
- R3: On a clock with in_valid=1, phase_out is loaded with bits [31:16] of the chosen accumulator as it stood before that clock's addition and appears on the next cycle; phase_valid equals in_valid delayed one cycle; with in_valid=0, phase_out holds.
- R4: With src_pin=0, the code is reg_sel: 00 chooses NCO1, 01 chooses NCO2, 10 chooses NCO3.
- R5: A sample whose code is 11 uses the previously chosen NCO and sets invalid_sel, which stays 1 until reset.
- R6: With src_pin=1, code bit 0 comes from the pin named by map_b0 and code bit 1 from the pin named by map_b1; map value 00 names pin 4, 01 pin 1, 10 pin 3, 11 pin 2; pin n is gpio_in[n-1].
- R7: gpio_in passes two flip-flops before decode: a pin change made before rising edge k is not used by samples accepted at edges k or k+1, and is used from edge k+2.
- R8: A write with freq_wr_en=1 and freq_wr_idx 00, 01 or 10 loads the word of NCO1, NCO2 or NCO3, and is used from the next sample on; index 11 is ignored; a write never alters any accumulator's phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe; steps accumulators and loads output |
| freq_wr_en | input | 1 | Frequency word write strobe |
| freq_wr_idx | input | 2 | Target oscillator of the write (00..10) |
| freq_wr_data | input | 32 | New frequency word |
| src_pin | input | 1 | 0: code from reg_sel, 1: code from pins |
| reg_sel | input | 2 | Register hop code |
| map_b0 | input | 2 | Pin remap for code bit 0 |
| map_b1 | input | 2 | Pin remap for code bit 1 |
| gpio_in | input | 4 | Asynchronous general-purpose pins 1..4 |
| phase_out | output | 16 | Registered phase of the active oscillator |
| phase_valid | output | 1 | phase_out carries a new sample |
| invalid_sel | output | 1 | Sticky flag for hop code 11 |

## Verification
The register path is driven with a rotating hop code and irregular idle gaps between samples. An output that matches the continuously counted phase after every return to an oscillator separates true phase coherence from restart-on-select. All sixteen pin-remap pairs are swept against all sixteen pin patterns, which exposes any swapped table entry or bit. A pin change is timed against samples one, two and three edges later to pin down the synchronizer depth. Frequency rewrites, an ignored index-11 write and the code-11 hold, tried both right after reset and mid-run, show step-only updates and hold behaviour.

// File: rtl/hop_nco_bank.sv
module hop_nco_bank #(
  parameter int PHASE_W = 32,
  parameter int OUT_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic               freq_wr_en,
  input  logic [1:0]         freq_wr_idx,
  input  logic [PHASE_W-1:0] freq_wr_data,
  input  logic               src_pin,
  input  logic [1:0]         reg_sel,
  input  logic [1:0]         map_b0,
  input  logic [1:0]         map_b1,
  input  logic [3:0]         gpio_in,
  output logic [OUT_W-1:0]   phase_out,
  output logic               phase_valid,
  output logic               invalid_sel
);
  localparam int NCO_N = 3;

  logic [PHASE_W-1:0] acc  [NCO_N];
  logic [PHASE_W-1:0] freq [NCO_N];
  logic [3:0]         pin_s1, pin_s2;
  logic [1:0]         sel_q;

  function automatic logic [1:0] pin_index(input logic [1:0] m);
    case (m)
      2'd0:    pin_index = 2'd3;
      2'd1:    pin_index = 2'd0;
      2'd2:    pin_index = 2'd2;
      default: pin_index = 2'd1;
    endcase
  endfunction

  wire [1:0] pin_code = {pin_s2[pin_index(map_b1)], pin_s2[pin_index(map_b0)]};
  wire [1:0] sel_code = src_pin ? pin_code : reg_sel;
  wire       sel_bad  = (sel_code == 2'd3);
  wire [1:0] sel_eff  = sel_bad ? sel_q : sel_code;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_s1 <= '0;
      pin_s2 <= '0;
    end else begin
      pin_s1 <= gpio_in;
      pin_s2 <= pin_s1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCO_N; i++) begin
        acc[i]  <= '0;
        freq[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NCO_N; i++)
        if (in_valid) acc[i] <= acc[i] + freq[i];
      if (freq_wr_en && freq_wr_idx != 2'd3)
        freq[freq_wr_idx] <= freq_wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q       <= 2'd0;
      phase_out   <= '0;
      phase_valid <= 1'b0;
      invalid_sel <= 1'b0;
    end else begin
      phase_valid <= in_valid;
      if (in_valid) begin
        sel_q     <= sel_eff;
        phase_out <= acc[sel_eff][PHASE_W-1 -: OUT_W];
        if (sel_bad) invalid_sel <= 1'b1;
      end
    end
  end
endmodule

module hop_nco_bank_chk #(
  parameter int PHASE_W = 32,
  parameter int OUT_W   = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic [1:0]         sel_code,
  input logic [1:0]         sel_q,
  input logic [OUT_W-1:0]   phase_out,
  input logic               phase_valid,
  input logic               invalid_sel,
  input logic [PHASE_W-1:0] acc0,
  input logic [PHASE_W-1:0] acc1,
  input logic [PHASE_W-1:0] acc2
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> phase_valid); // R3
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!phase_valid && $stable(phase_out))); // R3
  AST_ACC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(acc0) && $stable(acc1) && $stable(acc2))); // R2
  AST_BAD_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sel_code == 2'd3) |=> (sel_q == $past(sel_q) && invalid_sel)); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    invalid_sel |=> invalid_sel); // R5
  AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    sel_q != 2'd3); // R4
endmodule

bind hop_nco_bank hop_nco_bank_chk #(.PHASE_W(PHASE_W), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sel_code(sel_code),
  .sel_q(sel_q), .phase_out(phase_out), .phase_valid(phase_valid),
  .invalid_sel(invalid_sel), .acc0(acc[0]), .acc1(acc[1]), .acc2(acc[2])
);

// File: tb/test_hop_nco_bank.sv
module test_hop_nco_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        freq_wr_en = 1'b0;
  logic [1:0]  freq_wr_idx = '0;
  logic [31:0] freq_wr_data = '0;
  logic        src_pin = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [1:0]  map_b0 = '0;
  logic [1:0]  map_b1 = '0;
  logic [3:0]  gpio_in = '0;
  logic [15:0] phase_out;
  logic        phase_valid;
  logic        invalid_sel;

  int checks = 0;
  int errors = 0;
  logic [31:0] macc [3];
  logic [31:0] mfreq [3];
  int mprev = 0;

  always #4 clk = ~clk;

  hop_nco_bank i_hop_nco_bank (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .freq_wr_en(freq_wr_en),
    .freq_wr_idx(freq_wr_idx), .freq_wr_data(freq_wr_data), .src_pin(src_pin),
    .reg_sel(reg_sel), .map_b0(map_b0), .map_b1(map_b1), .gpio_in(gpio_in),
    .phase_out(phase_out), .phase_valid(phase_valid), .invalid_sel(invalid_sel)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int pin_bit(input logic [1:0] m);
    int pn;
    case (m)
      2'd0: pn = 4;
      2'd1: pn = 1;
      2'd2: pn = 3;
      default: pn = 2;
    endcase
    return pn - 1;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #2 rst_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      macc[i] = '0;
      mfreq[i] = '0;
    end
    mprev = 0;
  endtask

  task automatic wr(input logic [1:0] idx, input logic [31:0] d);
    freq_wr_en = 1'b1; freq_wr_idx = idx; freq_wr_data = d;
    @(posedge clk); #2;
    freq_wr_en = 1'b0;
    if (idx != 2'd3) mfreq[idx] = d;
  endtask

  task automatic idle(input int n, input string req);
    logic [15:0] held;
    held = phase_out;
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #2;
      chk(phase_valid, 0, req);
      chk(phase_out, held, req);
    end
  endtask

  task automatic sample(input int code, input string req);
    int eff;
    in_valid = 1'b1;
    @(posedge clk); #2;
    in_valid = 1'b0;
    eff = (code == 3) ? mprev : code;
    chk(phase_out, macc[eff][31:16], req);
    chk(phase_valid, 1, "R3");
    for (int i = 0; i < 3; i++) macc[i] = macc[i] + mfreq[i];
    mprev = eff;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    chk(phase_out, 0, "R1");
    chk(phase_valid, 0, "R1");
    chk(invalid_sel, 0, "R1");

    wr(2'd0, 32'h1234_5678);
    wr(2'd1, 32'h9ABC_DEF1);
    wr(2'd2, 32'h0F0F_0F0F);

    // R4 / R2 / R3: rotating register code with irregular gaps
    for (int k = 0; k < 60; k++) begin
      reg_sel = 2'(k % 3);
      sample(k % 3, "R4");
      if (k % 4 == 1) idle(k % 3 + 1, "R3");
    end
    chk(invalid_sel, 0, "R4");

    // R8: ignored index, then step change without phase reset
    wr(2'd3, 32'hFFFF_FFFF);
    for (int k = 0; k < 6; k++) begin
      reg_sel = 2'(k % 3);
      sample(k % 3, "R8");
    end
    wr(2'd1, 32'h0001_0000);
    wr(2'd2, 32'hF000_0001);
    for (int k = 0; k < 9; k++) begin
      reg_sel = 2'((k + 1) % 3);
      sample((k + 1) % 3, "R8");
    end

    // R7: synchronizer depth, pins mapped straight (bit0 pin1, bit1 pin2)
    src_pin = 1'b1; map_b0 = 2'd1; map_b1 = 2'd3;
    gpio_in = 4'b0001;
    idle(3, "R7");
    sample(1, "R7");
    gpio_in = 4'b0010;
    sample(1, "R7");
    sample(1, "R7");
    sample(2, "R7");

    // R5: code 11 holds and latches flag
    src_pin = 1'b0; reg_sel = 2'd3;
    sample(3, "R5");
    chk(invalid_sel, 1, "R5");
    sample(3, "R5");
    reg_sel = 2'd0;
    sample(0, "R5");
    chk(invalid_sel, 1, "R5");

    // R6: all remap pairs against all pin patterns
    src_pin = 1'b1;
    for (int m0 = 0; m0 < 4; m0++)
      for (int m1 = 0; m1 < 4; m1++)
        for (int g = 0; g < 16; g++) begin
          int code;
          map_b0 = 2'(m0); map_b1 = 2'(m1); gpio_in = 4'(g);
          code = (((g >> pin_bit(2'(m1))) & 1) << 1) | ((g >> pin_bit(2'(m0))) & 1);
          idle(2, "R7");
          sample(code, "R6");
        end

    // R1: after reset, code 11 uses NCO1
    src_pin = 1'b0; reg_sel = 2'd0; gpio_in = '0;
    do_reset();
    chk(invalid_sel, 0, "R1");
    wr(2'd0, 32'h0300_0000);
    wr(2'd1, 32'h7000_0000);
    reg_sel = 2'd3;
    for (int k = 0; k < 3; k++) sample(3, "R1");
    chk(invalid_sel, 1, "R5");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule